// File: doc/BRIEF.md
# Bus Master Priority Register with Lazy Distribution and Acknowledge

This block holds one high/low arbitration priority bit for each of four bus masters: processor 0, processor 1, the DMA read channel and the DMA write channel. Software programs the bits over a zero-wait-state APB slave. The block keeps a global copy and passes it to a configurable number of downstream arbiter stubs. Each stub takes the new value only when its arbiter starts a fresh nonsequential access. In this block that moment is marked by a one-cycle pulse per arbiter.

Each arbiter stub keeps a flag that says it has caught up since the last priority write. A read-only acknowledge is the AND of all these flags. Software writes new levels, then polls the acknowledge until every arbiter has adopted them. Each stub's local 4-bit priority vector is a port, so the arbitration logic can use it.

Top module: `bus_prio_ctrl`

## Requirements
- R1: After reset, the priority register reads 0, the acknowledge reads 0 and every arbiter's local priority vector is 0.
- R2: A write to offset 0x00 stores wdata bit 0 (processor 0), bit 4 (processor 1), bit 8 (DMA read) and bit 12 (DMA write), with 1 meaning high priority. A read of 0x00 returns those four bits in the same positions, and every other bit reads 0.
- R3: The acknowledge is bit 0 of offset 0x04 and is read-only: a write there changes nothing. Reads of any other offset return 0.
- R4: PREADY is always 1 and PSLVERR is always 0.
- R5: An arbiter's local vector changes only at a clock edge where its access-start pulse is high. It then takes the global value held before that edge.
- R6: Any write to 0x00, even one of the value already held, drives the acknowledge to 0 from the next cycle.
- R7: The acknowledge is 1 only when every arbiter has pulsed at least once since the last priority write (and since reset). It stays 0 until the last one has.
- R8: If an arbiter pulses in the same cycle as a priority write, it takes the old value and is not counted as caught up.
- R9: Each local vector holds processor 0 at bit 0, processor 1 at bit 1, DMA read at bit 2 and DMA write at bit 3. Arbiter i occupies bits 4*i+3 down to 4*i of `arb_prio`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| nseq_start | input | N_ARB | Per-arbiter pulse marking the start of a new nonsequential access |
| arb_prio | output | 4*N_ARB | Concatenated local priority vectors |
| prio_ack | output | 1 | All arbiters have adopted the current priority |

## Verification
The two functions that can meet in one cycle are a priority write and an arbiter's access-start pulse. The bench provokes this by raising the pulses on the same edge as the write's access phase. The check is that each pulsing arbiter keeps the old level and that the acknowledge drops and stays low until a later pulse. A rewrite of an unchanged value, done while the acknowledge is high, checks that the acknowledge drops on any write, not only on a change.

// File: rtl/prio_pkg.sv
// Package: shared constants, types and field packing for the priority block.
// Assumes a 4-master priority vector whose fields are spaced 4 bits apart.
package prio_pkg;
    localparam int N_MASTERS    = 4;
    localparam int FIELD_STRIDE = 4;
    localparam int OFS_PRIO     = 0;
    localparam int OFS_ACK      = 4;

    typedef logic [N_MASTERS-1:0] prio_vec_t;

    // Gather the spaced field bits of a 16-bit word into a compact vector.
    function automatic prio_vec_t gather_fields(input logic [15:0] w);
        prio_vec_t v;
        for (int m = 0; m < N_MASTERS; m++) v[m] = w[m*FIELD_STRIDE];
        return v;
    endfunction

    // Spread a compact vector back to its spaced field positions.
    function automatic logic [15:0] spread_fields(input prio_vec_t v);
        logic [15:0] w;
        w = '0;
        for (int m = 0; m < N_MASTERS; m++) w[m*FIELD_STRIDE] = v[m];
        return w;
    endfunction
endpackage

// File: rtl/prio_apb_regs.sv
// Module: APB register slave holding the global priority vector.
// Assumes zero wait states; DATA_W >= 16. Read data is combinational in the access phase.
module prio_apb_regs
    import prio_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic              ack_in,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output prio_vec_t         prio_q,
    output logic              prio_wr
);
    localparam logic [ADDR_W-1:0] A_PRIO = ADDR_W'(OFS_PRIO);
    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);

    logic access;

    // Decode the access phase and the priority write strobe.
    always_comb begin
        access  = psel && penable;
        prio_wr = access && pwrite && (paddr == A_PRIO);
    end

    // Hold the global priority vector.
    always_ff @(posedge clk) begin
        if (!rst_n)       prio_q <= '0;
        else if (prio_wr) prio_q <= gather_fields(pwdata[15:0]);
    end

    // Return read data for the addressed register.
    always_comb begin
        prdata = '0;
        if (access && !pwrite) begin
            if (paddr == A_PRIO)     prdata[15:0] = spread_fields(prio_q);
            else if (paddr == A_ACK) prdata[0]    = ack_in;
        end
    end

    // Fixed zero-wait, error-free response.
    always_comb begin
        pready  = 1'b1;
        pslverr = 1'b0;
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && paddr == A_PRIO) |->
        ((prdata & ~DATA_W'(16'h1111)) == '0));
endmodule

// File: rtl/prio_arb_copy.sv
// Module: one arbiter's local priority copy and its caught-up flag.
// Assumes nseq_start is a single-cycle pulse per new nonsequential access.
module prio_arb_copy
    import prio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  prio_vec_t global_prio,
    input  logic      prio_wr,
    input  logic      nseq_start,
    output prio_vec_t local_prio,
    output logic      caught_up
);
    // Adopt the global vector at the start of a new access.
    always_ff @(posedge clk) begin
        if (!rst_n)          local_prio <= '0;
        else if (nseq_start) local_prio <= global_prio;
    end

    // Track adoption since the last write; a write wins over a coincident pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          caught_up <= 1'b0;
        else if (prio_wr)    caught_up <= 1'b0;
        else if (nseq_start) caught_up <= 1'b1;
    end

    // R5
    local_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nseq_start |=> $stable(local_prio));
    // R8
    wr_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prio_wr |=> !caught_up);
    // R7
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nseq_start && !prio_wr) |=> caught_up);
endmodule

// File: rtl/prio_ack_reduce.sv
// Module: combines the per-arbiter caught-up flags into one acknowledge.
// Assumes at least one arbiter.
module prio_ack_reduce #(
    parameter int N_ARB = 10
) (
    input  logic [N_ARB-1:0] flags,
    output logic             ack
);
    // Acknowledge only when every arbiter has caught up.
    always_comb ack = &flags;
endmodule

// File: rtl/bus_prio_ctrl.sv
// Module: top of the priority register block; APB slave, N arbiter copies, acknowledge.
// Assumes a single clock domain and synchronous active-low reset.
module bus_prio_ctrl
    import prio_pkg::*;
#(
    parameter int N_ARB  = 10,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [ADDR_W-1:0]          paddr,
    input  logic [DATA_W-1:0]          pwdata,
    output logic [DATA_W-1:0]          prdata,
    output logic                       pready,
    output logic                       pslverr,
    input  logic [N_ARB-1:0]           nseq_start,
    output logic [N_MASTERS*N_ARB-1:0] arb_prio,
    output logic                       prio_ack
);
    prio_vec_t          prio_q;
    logic               prio_wr;
    logic [N_ARB-1:0]   flags;

    prio_apb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .ack_in(prio_ack), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .prio_q(prio_q), .prio_wr(prio_wr)
    );

    for (genvar i = 0; i < N_ARB; i++) begin : g_arb
        prio_vec_t loc;
        prio_arb_copy u_copy (
            .clk(clk), .rst_n(rst_n), .global_prio(prio_q), .prio_wr(prio_wr),
            .nseq_start(nseq_start[i]), .local_prio(loc), .caught_up(flags[i])
        );
        assign arb_prio[i*N_MASTERS +: N_MASTERS] = loc;

        // R7
        ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            prio_ack |-> (loc == prio_q));
    end

    prio_ack_reduce #(.N_ARB(N_ARB)) u_ack (.flags(flags), .ack(prio_ack));

    // R6
    wr_drops_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prio_wr |=> !prio_ack);
endmodule

// File: tb/bus_prio_ctrl_tb.sv
module bus_prio_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 10;
    localparam int AW  = 12;
    localparam int DW  = 32;
    localparam logic [N-1:0] ALL = '1;

    logic clk = 0, rst_n = 0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;
    logic pready, pslverr, prio_ack;
    logic [N-1:0] nseq = '0;
    logic [4*N-1:0] arb_prio;

    int checks = 0, fails = 0;
    int m_prio = 0;
    int m_local [N];
    int m_flag  [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_prio_ctrl #(.N_ARB(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .nseq_start(nseq), .arb_prio(arb_prio), .prio_ack(prio_ack)
    );

    function automatic int pack4(input logic [DW-1:0] d);
        return {28'd0, d[12], d[8], d[4], d[0]};
    endfunction

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_prio = 0;
            for (int i = 0; i < N; i++) begin m_local[i] = 0; m_flag[i] = 0; end
        end else begin
            bit wr;
            wr = psel && penable && pwrite && (paddr == 0);
            for (int i = 0; i < N; i++) begin
                if (nseq[i]) m_local[i] = m_prio;
                if (wr) m_flag[i] = 0;
                else if (nseq[i]) m_flag[i] = 1;
            end
            if (wr) m_prio = pack4(pwdata);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare model and design on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int all;
            all = 1;
            for (int i = 0; i < N; i++) begin
                if (m_flag[i] == 0) all = 0;
                check("R5 arb local", int'(arb_prio[4*i +: 4]), m_local[i]);
            end
            check("R7 ack", int'(prio_ack), all);
            check("R4 pready/pslverr", int'({pready, pslverr}), 2);
        end
    end

    task automatic apb_write(input int addr, input logic [DW-1:0] d, input logic [N-1:0] pulse);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = AW'(addr); pwdata = d;
        @(negedge clk); penable = 1; nseq = pulse;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; nseq = '0;
    endtask

    task automatic apb_read(input int addr, input int exp, input string req);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = AW'(addr);
        @(negedge clk); penable = 1; #1;
        check(req, int'(prdata), exp);
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk); nseq = m;
        @(negedge clk); nseq = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        apb_read(0, 0, "R1 prio reset");
        apb_read(4, 0, "R1 ack reset");
        check("R1 arb reset", int'(arb_prio[39:0] != 0), 0);
        // R2 field storage and reserved bits
        apb_write(0, 32'h0000_1111, '0);
        apb_read(0, 32'h1111, "R2 readback");
        apb_write(0, 32'hFFFF_FFFF, '0);
        apb_read(0, 32'h1111, "R2 reserved zero");
        apb_write(0, 32'h0000_0100, '0);
        // R7 partial catch-up keeps ack low
        pulse(10'h01F);
        @(negedge clk); #1 check("R7 partial ack", int'(prio_ack), 0);
        pulse(10'h3E0);
        @(negedge clk); #1 check("R7 full ack", int'(prio_ack), 1);
        apb_read(4, 1, "R3 ack read");
        // R9 mapping: DMA read only -> bit 2
        check("R9 mapping arb0", int'(arb_prio[3:0]), 4'b0100);
        check("R9 mapping arb9", int'(arb_prio[39:36]), 4'b0100);
        // R3 writes to ack register ignored
        apb_write(4, 32'h0, '0);
        @(negedge clk); #1 check("R3 ack write ignored", int'(prio_ack), 1);
        apb_read(0, 32'h0100, "R3 prio unchanged");
        apb_read(8, 0, "R3 unmapped read");
        // R6 same-value write drops ack
        apb_write(0, 32'h0000_0100, '0);
        #1 check("R6 same value ack", int'(prio_ack), 0);
        pulse(ALL);
        @(negedge clk); #1 check("R6 ack restored", int'(prio_ack), 1);
        // R8 write coincident with pulses
        apb_write(0, 32'h0000_1001, ALL);
        #1 check("R8 coincident ack", int'(prio_ack), 0);
        check("R8 old value kept", int'(arb_prio[3:0]), 4'b0100);
        apb_read(0, 32'h1001, "R8 new global");
        pulse(ALL);
        @(negedge clk); #1 check("R8 adopted later", int'(arb_prio[3:0]), 4'b1001);
        check("R8 ack after", int'(prio_ack), 1);
        // R5 idle cycles change nothing
        repeat (5) @(negedge clk);
        check("R5 idle hold", int'(arb_prio[7:4]), 4'b1001);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule